// File: doc/BRIEF.md
# Backlight PWM Generator with Staged Settings

This block produces one active-high pulse-width-modulated output, intended for driving a display backlight. A prescaler divides the input clock into ticks. A period counter divides the ticks into cycles. The output is high for a programmable number of ticks at the start of each cycle.

Software sets the block up through a simple register port made of valid, write, address and write-data signals, with registered read data. The divider and timing fields are written into shadow copies first. A rising edge on the commit bit stages those shadow values. The running waveform picks up the staged values only when the current cycle ends, so a cycle is never cut short or stretched by a change. When both bits of the debug field are set, the block is in manual mode: shadow values flow straight into the working set with no commit needed.

Register map (byte offsets, 32-bit data):

| Offset | Contents |
|--------|----------|
| 0x00 | Enable, bit 0 |
| 0x04 | Divider, bits [25:16] |
| 0x08 | Period, bits [11:0]; high time, bits [28:16] |
| 0x0C | Commit, bit 0 |
| 0x10 | Debug, bits [1:0] |

Top module: `bl_pwm_top`

## Requirements
- R1: After reset, `pwm_out` is 0 and the enable, divider and timing registers (offsets 0x00, 0x04, 0x08) all read back as 0.
- R2: A read returns data in the cycle after the request. The divider register at 0x04 reads back its shadow divider in bits [25:16]. The timing register at 0x08 reads back its shadow period in bits [11:0] and its shadow high time in bits [28:16]. All other bits read as 0, and reads show the shadow values even before any commit.
- R3: Writes to the divider or timing registers that are not followed by a commit do not change the waveform.
- R4: A write that takes bit 0 of the commit register (0x0C) from 0 to 1 stages the shadow values. Once they take effect, one output cycle lasts (period+1)*(divider+1) clocks and stays high for high*(divider+1) clocks.
- R5: While the block is enabled and not in manual mode, staged values take effect only at the end of the current output cycle. A high interval already in progress keeps its old length.
- R6: A high time of 0 keeps the output low. A high time greater than the period keeps the output high for the whole cycle.
- R7: Clearing bit 0 of the enable register (0x00) drives `pwm_out` low from the second clock edge after the write, and holds it low. The prescaler and period counters are held at zero while disabled.
- R8: When debug bits [1:0] at 0x10 are both 1, shadow writes take effect without a commit. With only one of the two bits set, a commit is still required.
- R9: Writing 1 to the commit bit while it already holds 1 stages nothing. Only a 0-to-1 change stages values.
- R10: The enable register reads back its stored bit in bit 0, with 0 in all other bits.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_valid | input | 1 | Register access request |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | AW | Byte address of the register |
| bus_wdata | input | DW | Write data |
| bus_rdata | output | DW | Read data, valid the cycle after a read |
| pwm_out | output | 1 | Registered PWM output, active high |

## Verification
The hardest case to reach from the ports is a commit that lands in the middle of an output cycle: it must wait for the cycle boundary. The bench handles this by watching `pwm_out` for a rising edge and issuing the commit write in the very next cycle, while a shorter high time is waiting in shadow. It then times the high interval already in progress, which must keep its old length. It repeats the commit bit without a falling edge to show that a level, not an edge, stages nothing. It also checks that single debug bits do not open the bypass.

// File: rtl/bl_pwm_pkg.sv
package bl_pwm_pkg;
  // Register byte offsets
  localparam int OFS_ENABLE = 'h00;
  localparam int OFS_DIVIDE = 'h04;
  localparam int OFS_TIMING = 'h08;
  localparam int OFS_COMMIT = 'h0C;
  localparam int OFS_DEBUG  = 'h10;
  // Field positions
  localparam int DIV_LSB  = 16;
  localparam int HIGH_LSB = 16;
  localparam int PER_LSB  = 0;
  // Debug code that opens the bypass
  localparam logic [1:0] BYPASS_CODE = 2'b11;
endpackage

// File: rtl/bl_pwm_regs.sv
module bl_pwm_regs
  import bl_pwm_pkg::*;
#(
  parameter int AW    = 8,
  parameter int DW    = 32,
  parameter int DIV_W = 10,
  parameter int PER_W = 12,
  localparam int HI_W = PER_W + 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             bus_valid,
  input  logic             bus_write,
  input  logic [AW-1:0]    bus_addr,
  input  logic [DW-1:0]    bus_wdata,
  output logic [DW-1:0]    bus_rdata,
  output logic             en_o,
  output logic             bypass_o,
  output logic             load_req,
  input  logic             load_ack,
  output logic [DIV_W-1:0] stg_div,
  output logic [PER_W-1:0] stg_per,
  output logic [HI_W-1:0]  stg_hi
);
  logic             en_q, cm_q, pend_q;
  logic [1:0]       dbg_q;
  logic [DIV_W-1:0] sh_div, st_div;
  logic [PER_W-1:0] sh_per, st_per;
  logic [HI_W-1:0]  sh_hi, st_hi;
  logic             wr, rd, commit_rise;
  logic [DW-1:0]    rd_val;

  assign wr = bus_valid & bus_write;
  assign rd = bus_valid & ~bus_write;
  assign commit_rise = wr && (bus_addr == AW'(OFS_COMMIT)) && bus_wdata[0] && !cm_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q   <= 1'b0;
      cm_q   <= 1'b0;
      dbg_q  <= '0;
      sh_div <= '0;
      sh_per <= '0;
      sh_hi  <= '0;
      st_div <= '0;
      st_per <= '0;
      st_hi  <= '0;
      pend_q <= 1'b0;
    end else begin
      if (wr) begin
        case (bus_addr)
          AW'(OFS_ENABLE): en_q  <= bus_wdata[0];
          AW'(OFS_DIVIDE): sh_div <= bus_wdata[DIV_LSB +: DIV_W];
          AW'(OFS_TIMING): begin
            sh_per <= bus_wdata[PER_LSB +: PER_W];
            sh_hi  <= bus_wdata[HIGH_LSB +: HI_W];
          end
          AW'(OFS_COMMIT): cm_q  <= bus_wdata[0];
          AW'(OFS_DEBUG):  dbg_q <= bus_wdata[1:0];
          default: ;
        endcase
      end
      if (commit_rise) begin
        st_div <= sh_div;
        st_per <= sh_per;
        st_hi  <= sh_hi;
        pend_q <= 1'b1;
      end else if (load_ack) begin
        pend_q <= 1'b0;
      end
    end
  end

  assign bypass_o = (dbg_q == BYPASS_CODE);
  assign en_o     = en_q;
  assign load_req = bypass_o | pend_q;
  assign stg_div  = bypass_o ? sh_div : st_div;
  assign stg_per  = bypass_o ? sh_per : st_per;
  assign stg_hi   = bypass_o ? sh_hi  : st_hi;

  always_comb begin
    rd_val = '0;
    case (bus_addr)
      AW'(OFS_ENABLE): rd_val[0] = en_q;
      AW'(OFS_DIVIDE): rd_val[DIV_LSB +: DIV_W] = sh_div;
      AW'(OFS_TIMING): begin
        rd_val[PER_LSB +: PER_W] = sh_per;
        rd_val[HIGH_LSB +: HI_W] = sh_hi;
      end
      AW'(OFS_COMMIT): rd_val[0] = cm_q;
      AW'(OFS_DEBUG):  rd_val[1:0] = dbg_q;
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)     bus_rdata <= '0;
    else if (rd) bus_rdata <= rd_val;
  end
endmodule

// File: rtl/bl_pwm_core.sv
module bl_pwm_core #(
  parameter int DIV_W = 10,
  parameter int PER_W = 12,
  localparam int HI_W = PER_W + 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic             bypass,
  input  logic             load_req,
  input  logic [DIV_W-1:0] stg_div,
  input  logic [PER_W-1:0] stg_per,
  input  logic [HI_W-1:0]  stg_hi,
  output logic             load_ack,
  output logic [DIV_W-1:0] wk_div,
  output logic [PER_W-1:0] wk_per,
  output logic [HI_W-1:0]  wk_hi,
  output logic             cyc_end,
  output logic             pwm_o
);
  logic [DIV_W-1:0] pre_cnt;
  logic [PER_W-1:0] per_cnt;
  logic             tick, load;

  // >= keeps the counters bounded after a manual-mode shrink
  assign tick     = (pre_cnt >= wk_div);
  assign cyc_end  = tick && (per_cnt >= wk_per);
  assign load     = bypass || (load_req && (!en || cyc_end));
  assign load_ack = load;

  always_ff @(posedge clk) begin
    if (rst) begin
      wk_div  <= '0;
      wk_per  <= '0;
      wk_hi   <= '0;
      pre_cnt <= '0;
      per_cnt <= '0;
      pwm_o   <= 1'b0;
    end else begin
      if (load) begin
        wk_div <= stg_div;
        wk_per <= stg_per;
        wk_hi  <= stg_hi;
      end
      if (!en) begin
        pre_cnt <= '0;
        per_cnt <= '0;
        pwm_o   <= 1'b0;
      end else begin
        pre_cnt <= tick ? '0 : pre_cnt + 1'b1;
        if (tick) per_cnt <= (per_cnt >= wk_per) ? '0 : per_cnt + 1'b1;
        pwm_o <= ({1'b0, per_cnt} < wk_hi);
      end
    end
  end
endmodule

// File: rtl/bl_pwm_top.sv
module bl_pwm_top #(
  parameter int AW    = 8,
  parameter int DW    = 32,
  parameter int DIV_W = 10,
  parameter int PER_W = 12
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          bus_valid,
  input  logic          bus_write,
  input  logic [AW-1:0] bus_addr,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  output logic          pwm_out
);
  localparam int HI_W = PER_W + 1;

  logic             en_w, bypass_w, load_req_w, load_ack_w, cyc_end_w;
  logic [DIV_W-1:0] stg_div_w, wk_div_w;
  logic [PER_W-1:0] stg_per_w, wk_per_w;
  logic [HI_W-1:0]  stg_hi_w, wk_hi_w;

  bl_pwm_regs #(.AW(AW), .DW(DW), .DIV_W(DIV_W), .PER_W(PER_W)) u_regs (
    .clk(clk), .rst(rst),
    .bus_valid(bus_valid), .bus_write(bus_write),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .en_o(en_w), .bypass_o(bypass_w),
    .load_req(load_req_w), .load_ack(load_ack_w),
    .stg_div(stg_div_w), .stg_per(stg_per_w), .stg_hi(stg_hi_w)
  );

  bl_pwm_core #(.DIV_W(DIV_W), .PER_W(PER_W)) u_core (
    .clk(clk), .rst(rst),
    .en(en_w), .bypass(bypass_w), .load_req(load_req_w),
    .stg_div(stg_div_w), .stg_per(stg_per_w), .stg_hi(stg_hi_w),
    .load_ack(load_ack_w),
    .wk_div(wk_div_w), .wk_per(wk_per_w), .wk_hi(wk_hi_w),
    .cyc_end(cyc_end_w), .pwm_o(pwm_out)
  );
endmodule

// File: rtl/bl_pwm_chk.sv
module bl_pwm_chk #(
  parameter int DIV_W = 10,
  parameter int PER_W = 12,
  localparam int HI_W = PER_W + 1
) (
  input logic             clk,
  input logic             rst,
  input logic             en,
  input logic             bypass,
  input logic             cyc_end,
  input logic [DIV_W-1:0] wk_div,
  input logic [PER_W-1:0] wk_per,
  input logic [HI_W-1:0]  wk_hi,
  input logic             pwm_out
);
  // R1
  reset_low_chk: assert property (@(posedge clk) rst |=> !pwm_out);

  // R5
  hold_mid_cycle_chk: assert property (@(posedge clk) disable iff (rst)
    (en && !bypass && !cyc_end) |=> ($stable(wk_div) && $stable(wk_per) && $stable(wk_hi)));

  // R6
  zero_high_chk: assert property (@(posedge clk) disable iff (rst)
    (wk_hi == '0) |=> !pwm_out);

  // R7
  disabled_low_chk: assert property (@(posedge clk) disable iff (rst)
    !en |=> !pwm_out);
endmodule

bind bl_pwm_top bl_pwm_chk #(.DIV_W(DIV_W), .PER_W(PER_W)) u_chk (
  .clk(clk), .rst(rst), .en(en_w), .bypass(bypass_w), .cyc_end(cyc_end_w),
  .wk_div(wk_div_w), .wk_per(wk_per_w), .wk_hi(wk_hi_w), .pwm_out(pwm_out)
);

// File: tb/sim_bl_pwm_top.sv
module sim_bl_pwm_top;
  localparam int AW = 8;
  localparam int DW = 32;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          bus_valid = 1'b0;
  logic          bus_write = 1'b0;
  logic [AW-1:0] bus_addr  = '0;
  logic [DW-1:0] bus_wdata = '0;
  logic [DW-1:0] bus_rdata;
  logic          pwm_out;
  int checks = 0;
  int fails  = 0;

  always #5 clk = ~clk;

  bl_pwm_top #(.AW(AW), .DW(DW)) u0 (
    .clk(clk), .rst(rst), .bus_valid(bus_valid), .bus_write(bus_write),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pwm_out(pwm_out)
  );

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    @(negedge clk);
    bus_valid = 1'b1; bus_write = 1'b1; bus_addr = AW'(a); bus_wdata = d;
    @(negedge clk);
    bus_valid = 1'b0; bus_write = 1'b0;
  endtask

  task automatic rd(input int a, output logic [31:0] d);
    @(negedge clk);
    bus_valid = 1'b1; bus_write = 1'b0; bus_addr = AW'(a);
    @(negedge clk);
    bus_valid = 1'b0;
    d = bus_rdata;
  endtask

  task automatic commit();
    wr('h0C, 32'd1);
    wr('h0C, 32'd0);
  endtask

  task automatic timing(input int hi, input int per);
    wr('h08, (32'(hi) << 16) | 32'(per));
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Clocks in one output cycle and high clocks in it, rising edge to rising edge
  task automatic measure(output int per, output int hi);
    int guard;
    logic prev;
    per = 0; hi = 0; guard = 0;
    do begin prev = pwm_out; @(negedge clk); guard++; end
    while (!(pwm_out && !prev) && guard < 2000);
    if (guard >= 2000) return;
    do begin
      if (pwm_out) hi++;
      per++;
      prev = pwm_out;
      @(negedge clk);
    end while (!(pwm_out && !prev) && per < 4000);
  endtask

  task automatic count_high(input int n, output int highs);
    highs = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (pwm_out) highs++;
    end
  endtask

  task automatic t_reset();
    logic [31:0] d;
    check(pwm_out == 1'b0, "R1 pwm after reset", pwm_out, 0);
    rd('h00, d); check(d == 0, "R1 enable reg", d, 0);
    rd('h04, d); check(d == 0, "R1 divider reg", d, 0);
    rd('h08, d); check(d == 0, "R1 timing reg", d, 0);
  endtask

  task automatic t_readback();
    logic [31:0] d;
    wr('h04, 32'hFFFF_FFFF);
    rd('h04, d); check(d == 32'h03FF_0000, "R2 divider field", d, 32'h03FF_0000);
    wr('h08, 32'hFFFF_FFFF);
    rd('h08, d); check(d == 32'h1FFF_0FFF, "R2 timing fields", d, 32'h1FFF_0FFF);
    wr('h00, 32'hFFFF_FFFF);
    rd('h00, d); check(d == 32'h1, "R10 enable set readback", d, 1);
    check(pwm_out == 1'b0, "R3 uncommitted shadow no output", pwm_out, 0);
    wr('h00, 32'h0);
    rd('h00, d); check(d == 32'h0, "R10 enable clear readback", d, 0);
  endtask

  task automatic t_basic();
    int p, h;
    wr('h04, 32'(1) << 16);
    timing(4, 9);
    commit();
    wr('h00, 1);
    idle(60);
    measure(p, h);
    check(p == 20, "R4 period div=1 per=9", p, 20);
    check(h == 8,  "R4 high div=1 hi=4", h, 8);
    wr('h04, 0);
    timing(5, 15);
    commit();
    idle(80);
    measure(p, h);
    check(p == 16, "R4 period div=0 per=15", p, 16);
    check(h == 5,  "R4 high div=0 hi=5", h, 5);
  endtask

  task automatic t_no_commit();
    int p, h;
    timing(12, 15);
    idle(100);
    measure(p, h);
    check(p == 16 && h == 5, "R3 shadow write ignored", {p, h}, {32'd16, 32'd5});
  endtask

  task automatic t_boundary();
    int p, h, run;
    logic prev;
    timing(10, 19);
    commit();
    idle(80);
    measure(p, h);
    check(p == 20 && h == 10, "R4 old config", {p, h}, {32'd20, 32'd10});
    timing(3, 19);
    prev = 1'b1;
    do begin prev = pwm_out; @(negedge clk); end while (!(pwm_out && !prev));
    bus_valid = 1'b1; bus_write = 1'b1; bus_addr = AW'('h0C); bus_wdata = 32'd1;
    run = 1;
    @(negedge clk);
    bus_valid = 1'b0; bus_write = 1'b0;
    while (pwm_out && run < 100) begin run++; @(negedge clk); end
    check(run == 10, "R5 high in progress keeps old length", run, 10);
    wr('h0C, 0);
    idle(60);
    measure(p, h);
    check(p == 20 && h == 3, "R5 new config after boundary", {p, h}, {32'd20, 32'd3});
  endtask

  task automatic t_extremes();
    int n;
    timing(10, 9);
    commit();
    idle(60);
    count_high(100, n);
    check(n == 100, "R6 high = period+1 stays high", n, 100);
    timing(32'h1FFF, 9);
    commit();
    idle(60);
    count_high(100, n);
    check(n == 100, "R6 high max stays high", n, 100);
    timing(0, 9);
    commit();
    idle(60);
    count_high(100, n);
    check(n == 0, "R6 high zero stays low", n, 0);
  endtask

  task automatic t_enable();
    int n;
    timing(10, 9);
    commit();
    idle(40);
    wr('h00, 0);
    @(negedge clk);
    check(pwm_out == 1'b0, "R7 low after disable", pwm_out, 0);
    count_high(50, n);
    check(n == 0, "R7 held low while disabled", n, 0);
    timing(3, 9);
    commit();
    wr('h00, 1);
    idle(3);
    count_high(3, n);
    check(n == 0, "R7 counters restart from zero", n, 0);
  endtask

  task automatic t_commit_level();
    int p, h;
    wr('h04, 0);
    timing(2, 7);
    wr('h0C, 1);
    idle(60);
    measure(p, h);
    check(p == 8 && h == 2, "R9 first rise stages", {p, h}, {32'd8, 32'd2});
    timing(6, 7);
    wr('h0C, 1);
    idle(60);
    measure(p, h);
    check(p == 8 && h == 2, "R9 repeated 1 ignored", {p, h}, {32'd8, 32'd2});
    wr('h0C, 0);
    wr('h0C, 1);
    idle(60);
    measure(p, h);
    check(p == 8 && h == 6, "R9 new rise stages", {p, h}, {32'd8, 32'd6});
    wr('h0C, 0);
  endtask

  task automatic t_bypass();
    int p, h, n;
    logic [31:0] d;
    wr('h10, 1);
    timing(0, 7);
    idle(60);
    measure(p, h);
    check(p == 8 && h == 6, "R8 one debug bit no bypass", {p, h}, {32'd8, 32'd6});
    wr('h10, 2);
    timing(0, 7);
    idle(60);
    measure(p, h);
    check(p == 8 && h == 6, "R8 other debug bit no bypass", {p, h}, {32'd8, 32'd6});
    wr('h10, 3);
    rd('h10, d); check(d == 3, "R8 debug readback", d, 3);
    timing(8, 7);
    idle(30);
    count_high(50, n);
    check(n == 50, "R8 bypass applies without commit", n, 50);
    timing(0, 7);
    idle(30);
    count_high(50, n);
    check(n == 0, "R8 bypass zero high", n, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_readback();
    t_basic();
    t_no_commit();
    t_boundary();
    t_extremes();
    t_enable();
    t_commit_level();
    t_bypass();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule